// File: doc/BRIEF.md
# Strobed Multiplexed-Bus Register Access Port

This block sits on the peripheral side of a multiplexed address/data bus. The bus is controlled by an address strobe and a data strobe, both active low, and neither has any phase relation to the peripheral clock. Each strobe, together with its qualifiers and the bus lines, passes through a multi-stage synchronizer. When the address strobe returns high, the block captures the register address, the primary chip select and the interrupt-acknowledge qualifier. When a selected data strobe falls, the block issues a single-cycle internal write pulse or read pulse.

Between accepted accesses to this device, the block enforces a recovery window measured in peripheral-clock cycles. A selected data-strobe fall that arrives too early is flagged and discarded. Traffic that does not select the device leaves the window alone. Every rising edge of the address strobe also produces a one-cycle hook for the interrupt section. A small register array and a set of pending bits are included only to exercise the port.

Top module: `mbus_regif`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) clears the latched address to 0, the qualifiers, the pending bits and all pulses. It leaves the recovery window expired, so the first selected access after reset is accepted.
- R2: On each synchronized rising edge of `as_n_i`, `acc_addr_o` takes the value the bus held at that edge. The primary select and the acknowledge qualifier are latched at the same edge.
- R3: A write is accepted on a synchronized falling edge of `ds_n_i` when all of these hold: the latched primary select is 1, `cs_sec_i` is 1, `rd_wr_i` is 0 (0 = write, 1 = read), the latched acknowledge is 0, and the recovery window has expired. An accepted write gives a one-cycle `wr_stb_o` and stores the bus value into register `acc_addr_o % NREG`.
- R4: A write with the latched primary select at 0, or with `cs_sec_i` at 0, produces no strobe and leaves the register unchanged.
- R5: `bus_oe_o` is 1 only when `ds_n_i` is 0, the latched primary select is 1, `cs_sec_i` is 1, `rd_wr_i` is 1 and the latched acknowledge is 0. While it is 1, `bus_ad_o` carries the addressed register.
- R6: An accepted read gives a one-cycle `rd_stb_o`. The register contents are not altered.
- R7: A selected data-strobe fall detected fewer than RECOV_CYC (4) clocks after the previous accepted one raises `recov_viol_o` for one cycle and produces no strobe or write. A fall exactly 4 clocks later is accepted. A violating access does not restart the window.
- R8: A data-strobe fall that is not selected neither restarts nor extends the recovery window.
- R9: Each synchronized rising edge of `as_n_i` gives a one-cycle `as_pulse_o` and ORs `irq_src_i` into `irq_pend_o`. Changes on `irq_src_i` with no address-strobe edge leave `irq_pend_o` unchanged.
- R10: A selected access whose latched acknowledge is 1 is an acknowledge cycle. It performs no register write, emits no strobe, and clears `irq_pend_o`.
- R11: `busy_o` rises together with the strobe of an accepted access and falls after the synchronized rising edge of `ds_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ad_i | input | DATA_W | Multiplexed address/data lines, inbound |
| bus_ad_o | output | DATA_W | Read data driven onto the bus |
| bus_oe_o | output | 1 | Output enable for `bus_ad_o` |
| as_n_i | input | 1 | Address strobe, active low |
| ds_n_i | input | 1 | Data strobe, active low |
| cs_pri_i | input | 1 | Primary chip select, latched with the address |
| cs_sec_i | input | 1 | Secondary chip select, sampled at data-strobe fall |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| iack_i | input | 1 | Interrupt-acknowledge qualifier |
| irq_src_i | input | IRQ_W | Interrupt sources sampled on address-strobe edges |
| irq_pend_o | output | IRQ_W | Pending interrupt bits |
| acc_addr_o | output | ADDR_W | Latched register address |
| wr_stb_o | output | 1 | One-cycle write pulse |
| rd_stb_o | output | 1 | One-cycle read pulse |
| recov_viol_o | output | 1 | One-cycle recovery-violation flag |
| as_pulse_o | output | 1 | One-cycle hook per address-strobe rise |
| busy_o | output | 1 | Selected access in progress |

## Verification
Two events can land in the same cycle: the recovery counter running out, and the next selected data-strobe fall being detected. The bench provokes this by placing the second fall exactly four clocks after an accepted one, and expects a write strobe rather than a violation. It repeats the test with a fall three clocks after an accepted one, which must violate. It also places a non-selected fall, and separately a violating fall, inside the window and then a selected fall at four clocks. The scoreboard expects one accepted strobe per selected fall at or after the boundary, and reports any unexpected or missing pulse.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [1:0] {
        ACC_WRITE = 2'd0,
        ACC_READ  = 2'd1,
        ACC_ACK   = 2'd2
    } acc_kind_e;

    // Classify a selected access from its qualifiers
    function automatic acc_kind_e classify(input logic iack, input logic rd);
        if (iack)    return ACC_ACK;
        else if (rd) return ACC_READ;
        else         return ACC_WRITE;
    endfunction

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int           W       = 8,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mbus_recov.sv
module mbus_recov #(
    parameter int RECOV_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic ready_o
);
    localparam int CW = $clog2(RECOV_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)           cnt_d = CW'(RECOV_CYC - 1);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q == '0);

    AST_LOAD_ONLY_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> cnt_q == '0);  // R7
endmodule

// File: rtl/mbus_regs.sv
module mbus_regs #(
    parameter int NREG   = 4,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_d [NREG];
    logic [DATA_W-1:0] mem_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            mem_d[g] = mem_q[g];
            if (we_i && widx_i == IDX_W'(g)) mem_d[g] = wdata_i;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/mbus_regif.sv
module mbus_regif #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SYNC_STG  = 2,
    parameter int RECOV_CYC = 4,
    parameter int NREG      = 4,
    parameter int IRQ_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_ad_i,
    output logic [DATA_W-1:0] bus_ad_o,
    output logic              bus_oe_o,
    input  logic              as_n_i,
    input  logic              ds_n_i,
    input  logic              cs_pri_i,
    input  logic              cs_sec_i,
    input  logic              rd_wr_i,
    input  logic              iack_i,
    input  logic [IRQ_W-1:0]  irq_src_i,
    output logic [IRQ_W-1:0]  irq_pend_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic              wr_stb_o,
    output logic              rd_stb_o,
    output logic              recov_viol_o,
    output logic              as_pulse_o,
    output logic              busy_o
);
    import mbus_pkg::*;

    localparam int IDX_W = $clog2(NREG);
    localparam int SW    = DATA_W + 6;
    localparam logic [SW-1:0] SYNC_RST = {2'b11, {(SW-2){1'b0}}};

    typedef struct packed {
        logic              as_prev;
        logic              ds_prev;
        logic [ADDR_W-1:0] addr;
        logic              cs_pri;
        logic              iack;
        logic              wr_stb;
        logic              rd_stb;
        logic              viol;
        logic              as_pulse;
        logic              busy;
        logic [IRQ_W-1:0]  pend;
    } st_t;

    st_t st_d, st_q;

    logic [SW-1:0]     sync_in, sync_out;
    logic              as_s, ds_s, cs_sec_s, rd_wr_s, iack_s, cs_pri_s;
    logic [DATA_W-1:0] bus_s;
    logic              rec_ready, rec_load, reg_we;
    logic [DATA_W-1:0] rdata;
    logic              as_rise, ds_fall, ds_rise, sel_fall;
    acc_kind_e         kind;

    // Strobes, qualifiers and bus travel through the same stages so
    // the captured values line up with the detected strobe edge.
    assign sync_in = {as_n_i, ds_n_i, cs_sec_i, rd_wr_i, iack_i, cs_pri_i, bus_ad_i};

    mbus_sync #(.W(SW), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sync_in),
        .q_o   (sync_out)
    );

    assign {as_s, ds_s, cs_sec_s, rd_wr_s, iack_s, cs_pri_s, bus_s} = sync_out;

    mbus_recov #(.RECOV_CYC(RECOV_CYC)) u_recov (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (rec_load),
        .ready_o (rec_ready)
    );

    mbus_regs #(.NREG(NREG), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .widx_i  (st_q.addr[IDX_W-1:0]),
        .wdata_i (bus_s),
        .ridx_i  (st_q.addr[IDX_W-1:0]),
        .rdata_o (rdata)
    );

    assign as_rise  = as_s & ~st_q.as_prev;
    assign ds_fall  = ~ds_s & st_q.ds_prev;
    assign ds_rise  = ds_s & ~st_q.ds_prev;
    assign sel_fall = ds_fall & st_q.cs_pri & cs_sec_s;
    assign kind     = classify(st_q.iack, rd_wr_s);

    always_comb begin
        st_d          = st_q;
        st_d.as_prev  = as_s;
        st_d.ds_prev  = ds_s;
        st_d.wr_stb   = 1'b0;
        st_d.rd_stb   = 1'b0;
        st_d.viol     = 1'b0;
        st_d.as_pulse = 1'b0;
        rec_load      = 1'b0;
        reg_we        = 1'b0;

        if (as_rise) begin
            st_d.addr     = bus_s[ADDR_W-1:0];
            st_d.cs_pri   = cs_pri_s;
            st_d.iack     = iack_s;
            st_d.as_pulse = 1'b1;
            st_d.pend     = st_q.pend | irq_src_i;
        end

        if (sel_fall) begin
            if (!rec_ready) begin
                st_d.viol = 1'b1;
            end else begin
                rec_load  = 1'b1;
                st_d.busy = 1'b1;
                case (kind)
                    ACC_WRITE: begin
                        st_d.wr_stb = 1'b1;
                        reg_we      = 1'b1;
                    end
                    ACC_READ:  st_d.rd_stb = 1'b1;
                    default:   st_d.pend   = '0;
                endcase
            end
        end

        if (ds_rise) st_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.as_prev <= 1'b1;
            st_q.ds_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_oe_o     = ~ds_n_i & st_q.cs_pri & cs_sec_i & rd_wr_i & ~st_q.iack;
    assign bus_ad_o     = rdata;
    assign irq_pend_o   = st_q.pend;
    assign acc_addr_o   = st_q.addr;
    assign wr_stb_o     = st_q.wr_stb;
    assign rd_stb_o     = st_q.rd_stb;
    assign recov_viol_o = st_q.viol;
    assign as_pulse_o   = st_q.as_pulse;
    assign busy_o       = st_q.busy;

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);  // R3
    AST_AS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        as_pulse_o |=> !as_pulse_o);  // R9
    AST_BUSY_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_o || rd_stb_o) |-> busy_o);  // R11
    AST_VIOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        recov_viol_o |-> !(wr_stb_o || rd_stb_o));  // R7
endmodule

// File: tb/test_mbus_regif.sv
`timescale 1ns/1ps
module test_mbus_regif;

    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_VIOL = 2'd2;

    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] addr;
        logic [7:0] data;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_ad_i = '0;
    logic [7:0] bus_ad_o;
    logic       bus_oe_o;
    logic       as_n = 1'b1, ds_n = 1'b1;
    logic       cs_pri = 1'b0, cs_sec = 1'b0, rd_wr = 1'b0, iack = 1'b0;
    logic [3:0] irq_src = '0;
    logic [3:0] irq_pend;
    logic [7:0] acc_addr;
    logic       wr_stb, rd_stb, viol, as_pulse, busy;

    int   n_cmp = 0, n_bad = 0, as_cnt = 0;
    exp_t sb_q[$];
    logic [7:0] model [4];
    logic [7:0] cur_addr = '0;

    always #4 clk = ~clk;

    mbus_regif i_mbus_regif (
        .clk(clk), .rst_n(rst_n), .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o),
        .bus_oe_o(bus_oe_o), .as_n_i(as_n), .ds_n_i(ds_n), .cs_pri_i(cs_pri),
        .cs_sec_i(cs_sec), .rd_wr_i(rd_wr), .iack_i(iack), .irq_src_i(irq_src),
        .irq_pend_o(irq_pend), .acc_addr_o(acc_addr), .wr_stb_o(wr_stb),
        .rd_stb_o(rd_stb), .recov_viol_o(viol), .as_pulse_o(as_pulse), .busy_o(busy)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(logic [1:0] k, logic [7:0] d);
        exp_t e;
        e.kind = k; e.addr = cur_addr; e.data = d;
        sb_q.push_back(e);
    endtask

    task automatic addr_phase(logic [7:0] a, logic c0, logic ia);
        as_n = 1'b0; bus_ad_i = a; cs_pri = c0; iack = ia;
        tick(2);
        as_n = 1'b1;
        tick(4);
        cur_addr = a;
    endtask

    // Full write; expected only when the access should be accepted
    task automatic wr_acc(logic [7:0] d, logic sec, bit expect_stb);
        rd_wr = 1'b0; cs_sec = sec; bus_ad_i = d;
        if (expect_stb) push(K_WR, d);
        ds_n = 1'b0; tick(3);
        ds_n = 1'b1; tick(6);
        cs_sec = 1'b1;
    endtask

    task automatic rd_acc();
        logic [7:0] e;
        e = model[cur_addr[1:0]];
        rd_wr = 1'b1; cs_sec = 1'b1;
        push(K_RD, e);
        ds_n = 1'b0; tick(1);
        chk(bus_oe_o == 1'b1, "R5 oe during read", bus_oe_o, 1);
        chk(bus_ad_o == e, "R5 read data", bus_ad_o, e);
        tick(3);
        chk(busy == 1'b1, "R11 busy during access", busy, 1);
        tick(1);
        ds_n = 1'b1; tick(1);
        chk(bus_oe_o == 1'b0, "R5 oe after DS high", bus_oe_o, 0);
        tick(4);
        chk(busy == 1'b0, "R11 busy after DS rise", busy, 0);
        tick(2);
        rd_wr = 1'b0;
    endtask

    always @(posedge clk) if (as_pulse) as_cnt <= as_cnt + 1;

    // Monitor: every pulse must match the oldest expected item
    always @(negedge clk) begin
        if (rst_n && (wr_stb || rd_stb || viol)) begin
            if (sb_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R3/R4/R7 unexpected pulse actual=%0h expected=0",
                         {wr_stb, rd_stb, viol});
            end else begin
                exp_t e;
                logic [1:0] k;
                e = sb_q.pop_front();
                k = wr_stb ? K_WR : (rd_stb ? K_RD : K_VIOL);
                chk(k == e.kind, "R3/R6/R7 pulse kind", k, e.kind);
                chk(acc_addr == e.addr, "R2 strobe address", acc_addr, e.addr);
                if (k == K_RD)
                    chk(bus_ad_o == e.data, "R6 read value", bus_ad_o, e.data);
            end
        end
    end

    initial begin
        #1200000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int pulses;
        for (int i = 0; i < 4; i++) model[i] = '0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk(acc_addr == 8'h00, "R1 address", acc_addr, 0);
        chk(irq_pend == 4'h0, "R1 pending", irq_pend, 0);
        chk(bus_oe_o == 1'b0, "R1 oe", bus_oe_o, 0);
        chk({wr_stb, rd_stb, viol, busy} == 4'b0, "R1 pulses", {wr_stb, rd_stb, viol, busy}, 0);

        // R1 first access accepted, R2 latch, R3 writes
        addr_phase(8'h21, 1'b1, 1'b0);
        chk(acc_addr == 8'h21, "R2 latched address", acc_addr, 8'h21);
        wr_acc(8'h5A, 1'b1, 1'b1); model[1] = 8'h5A;
        addr_phase(8'h22, 1'b1, 1'b0);
        wr_acc(8'hC3, 1'b1, 1'b1); model[2] = 8'hC3;
        addr_phase(8'h21, 1'b1, 1'b0); rd_acc();   // R6
        addr_phase(8'h22, 1'b1, 1'b0); rd_acc();   // R6

        // R5 read without secondary select: no enable
        rd_wr = 1'b1; cs_sec = 1'b0; ds_n = 1'b0; tick(1);
        chk(bus_oe_o == 1'b0, "R5 oe without cs_sec", bus_oe_o, 0);
        tick(3); ds_n = 1'b1; tick(6); cs_sec = 1'b1; rd_wr = 1'b0;

        // R4 unselected writes ignored
        addr_phase(8'h23, 1'b0, 1'b0);
        wr_acc(8'h77, 1'b1, 1'b0);
        addr_phase(8'h23, 1'b1, 1'b0);
        wr_acc(8'h88, 1'b0, 1'b0);
        rd_acc();  // R4 register still zero

        // R7 early fall at 3 clocks violates
        addr_phase(8'h20, 1'b1, 1'b0);
        rd_wr = 1'b0; cs_sec = 1'b1; bus_ad_i = 8'h11;
        push(K_WR, 8'h11); ds_n = 1'b0; tick(2);
        ds_n = 1'b1; tick(1);
        bus_ad_i = 8'h22; push(K_VIOL, 8'h00); ds_n = 1'b0; tick(1);
        ds_n = 1'b1; tick(8);
        model[0] = 8'h11;
        rd_acc();  // R7 violating data not stored

        // R7 fall at exactly 4 clocks accepted
        bus_ad_i = 8'h33; push(K_WR, 8'h33); ds_n = 1'b0; tick(2);
        ds_n = 1'b1; tick(2);
        bus_ad_i = 8'h44; push(K_WR, 8'h44); ds_n = 1'b0; tick(2);
        ds_n = 1'b1; tick(8);
        model[0] = 8'h44;

        // R8 non-selected fall inside window does not restart it
        bus_ad_i = 8'h55; push(K_WR, 8'h55); ds_n = 1'b0; tick(1);
        ds_n = 1'b1; tick(1);
        cs_sec = 1'b0; ds_n = 1'b0; tick(1);
        cs_sec = 1'b1; ds_n = 1'b1; tick(1);
        bus_ad_i = 8'h66; push(K_WR, 8'h66); ds_n = 1'b0; tick(2);
        ds_n = 1'b1; tick(8);
        // R7 violating fall does not restart window
        bus_ad_i = 8'h77; push(K_WR, 8'h77); ds_n = 1'b0; tick(1);
        ds_n = 1'b1; tick(1);
        push(K_VIOL, 8'h00); ds_n = 1'b0; tick(1);
        ds_n = 1'b1; tick(1);
        bus_ad_i = 8'h78; push(K_WR, 8'h78); ds_n = 1'b0; tick(2);
        ds_n = 1'b1; tick(8);
        model[0] = 8'h78;
        rd_acc();

        // R9 pending bits only on address-strobe edges
        irq_src = 4'b0101; tick(6);
        chk(irq_pend == 4'h0, "R9 no AS no set", irq_pend, 0);
        pulses = as_cnt;
        addr_phase(8'h30, 1'b0, 1'b0);
        chk(irq_pend == 4'b0101, "R9 set on AS", irq_pend, 4'b0101);
        chk(as_cnt == pulses + 1, "R9 one pulse per AS", as_cnt, pulses + 1);
        irq_src = 4'b1000; tick(4);
        chk(irq_pend == 4'b0101, "R9 stable without AS", irq_pend, 4'b0101);
        irq_src = 4'b0000;

        // R10 acknowledge cycle
        addr_phase(8'h21, 1'b1, 1'b1);
        wr_acc(8'hEE, 1'b1, 1'b0);
        chk(irq_pend == 4'h0, "R10 pending cleared", irq_pend, 0);
        addr_phase(8'h21, 1'b1, 1'b0);
        rd_acc();  // R10 register keeps 5A

        tick(10);
        chk(sb_q.size() == 0, "R3/R6/R7 missing pulses", sb_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule